// File: doc/BRIEF.md
# PCI Interrupt Summary and Mask Unit

This unit gathers nineteen level-sensitive PCI interrupt lines (four lines from each of four option slots, plus the I/O bridge cascade line, the IDE line and the USB line) into three byte-wide I/O ports. Each line has its own mask bit. The unmasked, active lines are ORed into one registered request to the processor.

Software reaches the unit through a byte-wide strobed port that decodes three consecutive addresses. A write to one of these addresses replaces the mask byte of that port. A read returns the raw state of the lines in that port, whatever their mask bits hold. The masks cannot be read back.

The line inputs are asynchronous. They pass through a synchronizer before the read path or the request logic uses them. Reset leaves every line disabled.

Top module: `pirq_summary`

## Requirements
- R1: After reset every mask bit is 1 (disabled), so `cpu_irq` stays 0 even while all nineteen lines are high.
- R2: A write strobe to port k (address BASE_ADDR+k, k = 0, 1, 2) replaces all mask bits of that port with the written byte. A bit value of 1 disables its line and 0 enables it. Other ports keep their masks.
- R3: A read strobe returns the synchronized raw line state of the addressed port, independent of the mask. The mask value is never returned.
- R4: Port 0 layout: bits 3:0 are line A of slots 3..0 (bit n = slot n), bit 4 is the bridge cascade line, bit 5 is IDE, bit 6 is USB, and bit 7 is line B of slot 0.
- R5: Port 1 layout: bits 2:0 are line B of slots 1..3 (bit n = slot n+1), bits 6:3 are line C of slots 0..3 (bit n = slot n-3), and bit 7 is line D of slot 0.
- R6: Port 2 layout: bits 2:0 are line D of slots 1..3 (bit n = slot n+1). Bits 7:3 are reserved, always read as 0, and writes to them have no effect.
- R7: A write to any address outside BASE_ADDR..BASE_ADDR+2 changes no mask. A read at such an address returns 0x00, and so does the data bus when no read strobe is present.
- R8: `cpu_irq` is a registered OR of all lines that are active with their mask bit at 0. It reflects a mask write at the first clock edge after the edge that performs the write.
- R9: Each line passes through SYNC_STAGES flops, 2 by default. A change on a line driven between clock edges shows up in read data after two edges, and in `cpu_irq` after three edges.
- R10: The lines are level-sensitive. When an enabled line falls, `cpu_irq` falls three edges later, with no latched state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data (mask byte) |
| bus_rdata | output | 8 | Read data: raw line state of the addressed port |
| slot_int_a | input | 4 | Line A of slots 3..0 |
| slot_int_b | input | 4 | Line B of slots 3..0 |
| slot_int_c | input | 4 | Line C of slots 3..0 |
| slot_int_d | input | 4 | Line D of slots 3..0 |
| bridge_int | input | 1 | I/O bridge cascade line |
| ide_int | input | 1 | IDE line |
| usb_int | input | 1 | USB line |
| cpu_irq | output | 1 | Combined request to the processor |

## Verification
The bench builds the unit with its defaults: a 16-bit address, a base of 0x0804 and two synchronizer stages.

With the full 16-bit decode, the bench can reach addresses next to the window (0x0803 and 0x0807) and an alias that differs from the base only in high bits (0x0C04). It checks that none of them writes a mask.

With two stages, the exact latency of two edges to the read data and three edges to the request can be checked edge by edge. The bench also walks a single active line across all nineteen positions to pin down the packing.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int PORT_COUNT = 3;
    localparam int PORT_W     = 8;
    localparam int VEC_W      = PORT_COUNT * PORT_W;
    localparam int LINE_COUNT = 19;
    localparam int SLOTS      = 4;

    typedef logic [VEC_W-1:0] port_vec_t;

    // Implemented line positions across the three ports
    localparam port_vec_t IMPL_BITS = port_vec_t'((1 << LINE_COUNT) - 1);

    typedef enum logic [1:0] {
        PORT_LO   = 2'd0,
        PORT_MID  = 2'd1,
        PORT_HI   = 2'd2,
        PORT_NONE = 2'd3
    } port_sel_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH  = 19,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else if (s == 0) begin
                chain[s] <= d_async;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pirq_pack.sv
module pirq_pack
    import pirq_pkg::*;
(
    input  logic [SLOTS-1:0] int_a,
    input  logic [SLOTS-1:0] int_b,
    input  logic [SLOTS-1:0] int_c,
    input  logic [SLOTS-1:0] int_d,
    input  logic             bridge,
    input  logic             ide,
    input  logic             usb,
    output logic [LINE_COUNT-1:0] lines
);
    // Fixed wiring order; software decodes these positions
    always_comb begin
        lines        = '0;
        lines[3:0]   = int_a;
        lines[4]     = bridge;
        lines[5]     = ide;
        lines[6]     = usb;
        lines[7]     = int_b[0];
        lines[10:8]  = int_b[3:1];
        lines[14:11] = int_c;
        lines[15]    = int_d[0];
        lines[18:16] = int_d[3:1];
    end
endmodule

// File: rtl/pirq_decode.sv
module pirq_decode
    import pirq_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0804
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(PORT_COUNT - 1);
    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs = addr - BASE_ADDR;
        sel  = PORT_NONE;
        if (addr >= BASE_ADDR && addr <= LAST_ADDR) begin
            sel = port_sel_e'(offs[1:0]);
        end
    end
endmodule

// File: rtl/pirq_mask_bank.sv
module pirq_mask_bank
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  port_sel_e         sel,
    input  logic [PORT_W-1:0] wdata,
    output port_vec_t         mask_q
);
    for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port
        localparam logic [PORT_W-1:0] IMPL = IMPL_BITS[p*PORT_W +: PORT_W];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[p*PORT_W +: PORT_W] <= '1;
            end else if (wr_en && sel == port_sel_e'(p)) begin
                // reserved positions stay disabled
                mask_q[p*PORT_W +: PORT_W] <= (wdata & IMPL) | ~IMPL;
            end
        end
    end
endmodule

// File: rtl/pirq_summary.sv
module pirq_summary
    import pirq_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0804,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [3:0]        slot_int_a,
    input  logic [3:0]        slot_int_b,
    input  logic [3:0]        slot_int_c,
    input  logic [3:0]        slot_int_d,
    input  logic              bridge_int,
    input  logic              ide_int,
    input  logic              usb_int,
    output logic              cpu_irq
);
    logic [LINE_COUNT-1:0] lines_raw;
    logic [LINE_COUNT-1:0] lines_sync;
    port_vec_t             lines_s;
    port_vec_t             mask_q;
    port_sel_e             sel;

    pirq_pack u_pack (
        .int_a (slot_int_a),
        .int_b (slot_int_b),
        .int_c (slot_int_c),
        .int_d (slot_int_d),
        .bridge(bridge_int),
        .ide   (ide_int),
        .usb   (usb_int),
        .lines (lines_raw)
    );

    pirq_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(lines_raw),
        .q_sync (lines_sync)
    );

    assign lines_s = port_vec_t'(lines_sync);

    pirq_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    pirq_mask_bank u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .mask_q(mask_q)
    );

    // Read path: raw synchronized lines, mask not visible
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                PORT_LO:   bus_rdata = lines_s[0*PORT_W +: PORT_W];
                PORT_MID:  bus_rdata = lines_s[1*PORT_W +: PORT_W];
                PORT_HI:   bus_rdata = lines_s[2*PORT_W +: PORT_W];
                PORT_NONE: bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_irq <= 1'b0;
        end else begin
            cpu_irq <= |(lines_s & ~mask_q & IMPL_BITS);
        end
    end
endmodule

// File: rtl/pirq_summary_chk.sv
module pirq_summary_chk
    import pirq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0804
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cpu_irq,
    input port_vec_t         mask_q,
    input port_vec_t         lines_s
);
    logic in_win;
    assign in_win = (bus_addr >= BASE_ADDR) && (bus_addr <= BASE_ADDR + ADDR_W'(2));

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !cpu_irq);

    a_r2_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BASE_ADDR) |=> mask_q[7:0] == $past(bus_wdata));

    a_r3_read_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BASE_ADDR + ADDR_W'(1)) |-> bus_rdata == lines_s[15:8]);

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BASE_ADDR + ADDR_W'(2)) |-> bus_rdata[7:3] == 5'd0);

    a_r7_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && in_win) |=> $stable(mask_q));

    a_r8_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |=> !cpu_irq);
endmodule

bind pirq_summary pirq_summary_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cpu_irq  (cpu_irq),
    .mask_q   (mask_q),
    .lines_s  (lines_s)
);

// File: tb/pirq_summary_tb.sv
module pirq_summary_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  sa = '0, sb = '0, sc = '0, sd = '0;
    logic        br = 1'b0, ide = 1'b0, usb = 1'b0;
    logic        cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pirq_summary dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slot_int_a(sa), .slot_int_b(sb), .slot_int_c(sc), .slot_int_d(sd),
        .bridge_int(br), .ide_int(ide), .usb_int(usb), .cpu_irq(cpu_irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic all_lines(logic v);
        sa = {4{v}}; sb = {4{v}}; sc = {4{v}}; sd = {4{v}};
        br = v; ide = v; usb = v;
    endtask

    // Drive the line at a port/bit position, per the layout in R4..R6
    task automatic set_pos(int port, int bitn, logic v);
        if (port == 0) begin
            if (bitn < 4) sa[bitn] = v;
            else if (bitn == 4) br = v;
            else if (bitn == 5) ide = v;
            else if (bitn == 6) usb = v;
            else sb[0] = v;
        end else if (port == 1) begin
            if (bitn < 3) sb[bitn+1] = v;
            else if (bitn < 7) sc[bitn-3] = v;
            else sd[0] = v;
        end else begin
            sd[bitn+1] = v;
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        all_lines(1'b1);
        settle(4);
        check("R1 irq after reset, all lines high", {7'd0, cpu_irq}, 8'h00);
        rd(16'h0806, d);
        check("R6 reserved read as zero", d, 8'h07);
        all_lines(1'b0);
        settle(4);
    endtask

    task automatic t_layout;
        logic [7:0] d;
        for (int p = 0; p < 3; p++) begin
            for (int b = 0; b < ((p == 2) ? 3 : 8); b++) begin
                all_lines(1'b0);
                set_pos(p, b, 1'b1);
                settle(3);
                for (int q = 0; q < 3; q++) begin
                    rd(16'h0804 + 16'(q), d);
                    check(q == 0 ? "R4 port0 layout" : (q == 1 ? "R5 port1 layout" : "R6 port2 layout"),
                          d, (q == p) ? 8'(1 << b) : 8'h00);
                end
            end
        end
        all_lines(1'b0);
        settle(3);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        all_lines(1'b1);
        settle(4);
        wr(16'h0805, 8'hF7);                // enable line C of slot 0
        settle(1);
        check("R8 irq one edge after enabling write", {7'd0, cpu_irq}, 8'h01);
        rd(16'h0805, d);
        check("R3 read shows raw lines, not mask", d, 8'hFF);
        wr(16'h0805, 8'hFF);
        settle(1);
        check("R2 writing 1 disables line", {7'd0, cpu_irq}, 8'h00);
        wr(16'h0804, 8'h00);
        wr(16'h0804, 8'hFE);                // replace: only INTA slot0 enabled
        all_lines(1'b0);
        sa[1] = 1'b1;
        settle(4);
        check("R2 write replaces whole byte", {7'd0, cpu_irq}, 8'h00);
        sa[0] = 1'b1;
        settle(4);
        check("R2 remaining enabled bit asserts", {7'd0, cpu_irq}, 8'h01);
        wr(16'h0804, 8'hFF);
        settle(1);
        check("R2 port0 disabled again", {7'd0, cpu_irq}, 8'h00);
        all_lines(1'b0);
        settle(4);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        all_lines(1'b1);
        wr(16'h0806, 8'hF8);                // enable slots 1..3 line D only
        settle(3);
        check("R6 implemented bits of port2 enable", {7'd0, cpu_irq}, 8'h01);
        rd(16'h0806, d);
        check("R6 reserved read zero after write", d, 8'h07);
        wr(16'h0806, 8'h07);                // reserved bits 0 must stay ignored
        settle(1);
        check("R6 reserved write has no effect", {7'd0, cpu_irq}, 8'h00);
        all_lines(1'b0);
        settle(4);
    endtask

    task automatic t_stray;
        logic [7:0] d;
        all_lines(1'b1);
        wr(16'h0803, 8'h00);
        wr(16'h0807, 8'h00);
        wr(16'h0C04, 8'h00);
        settle(2);
        check("R7 stray writes change no mask", {7'd0, cpu_irq}, 8'h00);
        rd(16'h0807, d);
        check("R7 stray read returns zero", d, 8'h00);
        @(negedge clk);
        bus_addr = 16'h0804;
        #1 check("R7 no strobe drives zero", bus_rdata, 8'h00);
        all_lines(1'b0);
        settle(4);
    endtask

    task automatic t_sync_level;
        logic [7:0] d;
        wr(16'h0804, 8'hDF);                // enable IDE (bit 5)
        settle(3);
        @(negedge clk);
        ide = 1'b1;
        @(posedge clk); #1;
        bus_addr = 16'h0804; bus_rd = 1'b1; #0.5;
        check("R9 read unchanged after one edge", bus_rdata, 8'h00);
        bus_rd = 1'b0;
        @(posedge clk); #1;
        bus_rd = 1'b1; #0.5;
        check("R9 read updated after two edges", bus_rdata, 8'h20);
        bus_rd = 1'b0;
        check("R9 irq not yet after two edges", {7'd0, cpu_irq}, 8'h00);
        @(posedge clk); #1;
        check("R9 irq after three edges", {7'd0, cpu_irq}, 8'h01);
        settle(3);
        check("R10 irq holds while level high", {7'd0, cpu_irq}, 8'h01);
        @(negedge clk);
        ide = 1'b0;
        repeat (2) @(posedge clk);
        #1 check("R10 irq still high two edges after fall", {7'd0, cpu_irq}, 8'h01);
        @(posedge clk); #1;
        check("R10 irq falls three edges after line", {7'd0, cpu_irq}, 8'h00);
        rd(16'h0804, d);
        check("R10 read shows line low", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_mask();
        t_reserved();
        t_stray();
        t_sync_level();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule